// File: doc/BRIEF.md
# SPI Slave Port with Host-Request Flow Control

This block connects a processor to an external SPI master as a full-duplex slave. The processor writes an outgoing word into a holding register and reads incoming words from a small receive queue. The serial clock, slave select and data-in lines are brought into the system clock domain through synchronizer chains. Edges of the synchronized clock then drive the bit counter and the shifters. Clock polarity and phase are inputs, so all four standard SPI modes are supported. Words are 8 bits and travel most significant bit first.

A host-request output tells the external master when the slave is ready for the next word. A 2-bit field selects what it tracks: receive space, a fresh transmit word, or both. Releasing slave select before the last bit of a word arrives cancels that word. Processor-side status shows when the receive queue holds data and when a completed word was lost because the queue was full.

Top module: `spi_hreq_slave`

## Requirements
- R1: With `hreq_mode` = 2'b00 the `hreq` output stays low regardless of queue or transmit state.
- R2: With `hreq_mode` = 2'b01, `hreq` is high exactly when no word is in progress and the receive queue has a free entry. It is low once the queue holds 2 words.
- R3: With `hreq_mode` = 2'b10, `hreq` goes high after a word written through `tx_data`/`tx_wr` has been moved into the output shifter. It stays low after a word completes if no new word was written.
- R4: With `hreq_mode` = 2'b11, `hreq` is high only while the receive condition of R2 and the transmit condition of R3 both hold.
- R5: The first SCK edge of a word (while `ss_n` is low) drops `hreq` within the synchronizer latency. `hreq` stays low for the rest of that word.
- R6: If no new word was written before a word begins, the slave sends the last loaded word again.
- R7: Raising `ss_n` before the eighth sampled bit discards the partial word: nothing enters the queue, and the next full word is received correctly from its first bit.
- R8: `rx_not_empty` is high whenever the receive queue holds at least one word. It is low after reset.
- R9: A word that completes while the queue holds 2 words is dropped and sets `rx_overrun`. The flag stays set until the processor pulses `rx_rd`.
- R10: In every combination of `cpol` and `cpha`, 8 bits are exchanged MSB first. MOSI is sampled, and MISO changes, on the edges that the standard SPI mode for that combination defines.
- R11: The receive queue returns words in arrival order. `rx_data` shows the oldest word, and `rx_rd` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| hreq_mode | input | 2 | Host-request source: 00 off, 01 receive, 10 transmit, 11 both |
| tx_data | input | 8 | Word to transmit |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| rx_data | output | 8 | Oldest received word |
| rx_rd | input | 1 | Pop strobe for the receive queue; also clears overrun |
| rx_not_empty | output | 1 | Receive queue holds a word |
| rx_overrun | output | 1 | Sticky lost-word flag |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| hreq | output | 1 | Host-request handshake to the master |

## Verification
On every cycle the assertions check four things. `hreq` is forced low when disabled and falls right after a word's first clock edge. A released select clears the word state. A completed word sets the non-empty flag, or the overrun flag when the queue is full. Only the bench scenarios can show end-to-end properties. These are the bit order and edge choice in all four SPI modes, the resending of a stale transmit word, and the arrival order in the queue. They also cover that a word following an abort is received intact, and how the host-request gating behaves as the queue fills and the holding register is refilled.

// File: rtl/spi_hreq_pkg.sv
package spi_hreq_pkg;
   typedef enum logic [1:0] {
      HREQ_OFF  = 2'b00,
      HREQ_RX   = 2'b01,
      HREQ_TX   = 2'b10,
      HREQ_BOTH = 2'b11
   } hreq_mode_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= '0;
      else if (do_push & ~do_pop) count <= count + 1'b1;
      else if (do_pop & ~do_push) count <= count - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (do_push) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp, rp;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (do_push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
               if (do_pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wp] <= din;
         end

         assign dout = mem[rp];
      end
   endgenerate

   // R11
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sck_s,
   input  logic              ss_n_s,
   input  logic              mosi_s,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_wr,
   output logic              miso,
   output logic              word_start,
   output logic              word_done,
   output logic [WORD_W-1:0] word_data,
   output logic              busy,
   output logic              tx_loaded
);
   localparam int CW = $clog2(WORD_W);

   logic              sck_prev, busy_q, loaded_q, hold_full;
   logic [CW-1:0]     bit_cnt, tx_idx;
   logic [WORD_W-1:0] hold, tx_word, rx_sr, tx_view;
   logic              rise, fall, lead, trail, ss_act, samp, shft, last_bit, load;

   assign rise     = sck_s & ~sck_prev;
   assign fall     = ~sck_s & sck_prev;
   assign lead     = cpol ? fall : rise;
   assign trail    = cpol ? rise : fall;
   assign ss_act   = ~ss_n_s;
   assign samp     = ss_act & (cpha ? trail : lead);
   assign shft     = ss_act & (cpha ? lead : trail);
   assign last_bit = (bit_cnt == CW'(WORD_W-1));

   assign word_start = ss_act & lead & ~busy_q;
   assign word_done  = samp & last_bit;
   assign word_data  = {rx_sr[WORD_W-2:0], mosi_s};
   assign load       = ~busy_q & hold_full & ~word_start;

   assign tx_view   = tx_word << tx_idx;
   assign miso      = tx_view[WORD_W-1];
   assign busy      = busy_q;
   assign tx_loaded = loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev  <= 1'b0;
         busy_q    <= 1'b0;
         loaded_q  <= 1'b0;
         hold_full <= 1'b0;
         bit_cnt   <= '0;
         tx_idx    <= '0;
         hold      <= '0;
         tx_word   <= '0;
         rx_sr     <= '0;
      end else begin
         sck_prev <= sck_s;

         if (load) begin
            tx_word   <= hold;
            hold_full <= 1'b0;
         end
         if (tx_wr) begin
            hold      <= tx_data;
            hold_full <= 1'b1;
         end

         if (word_start)  loaded_q <= 1'b0;
         else if (load)   loaded_q <= 1'b1;

         if (!ss_act) begin
            bit_cnt <= '0;
            busy_q  <= 1'b0;
            tx_idx  <= '0;
         end else begin
            if (word_start) busy_q <= 1'b1;
            if (samp) begin
               rx_sr <= word_data;
               if (last_bit) begin
                  bit_cnt <= '0;
                  busy_q  <= 1'b0;
                  tx_idx  <= '0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            if (shft && busy_q) tx_idx <= tx_idx + 1'b1;
         end
      end
   end

   // R7
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_act |=> (bit_cnt == '0 && !busy_q && tx_idx == '0));

   // R3
   loaded_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |-> !busy_q);
endmodule

// File: rtl/spi_hreq_slave.sv
module spi_hreq_slave
   import spi_hreq_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int FIFO_DEPTH  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [1:0]        hreq_mode,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_wr,
   output logic [WORD_W-1:0] rx_data,
   input  logic              rx_rd,
   output logic              rx_not_empty,
   output logic              rx_overrun,
   input  logic              sck,
   input  logic              ss_n,
   input  logic              mosi,
   output logic              miso,
   output logic              hreq
);
   generate
      if (WORD_W < 2)      begin : g_bad_word  $error("WORD_W must be at least 2");      end
      if (FIFO_DEPTH < 1)  begin : g_bad_depth $error("FIFO_DEPTH must be at least 1");  end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic              sck_s, ss_n_s, mosi_s;
   logic              word_start, word_done, busy, tx_loaded;
   logic              fifo_full, fifo_empty, rx_cond, tx_cond;
   logic [WORD_W-1:0] word_data;
   hreq_mode_e        mode;

   spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .din(sck), .q(sck_s));
   spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .din(ss_n), .q(ss_n_s));
   spi_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .din(mosi), .q(mosi_s));

   spi_shift_core #(.WORD_W(WORD_W)) u_core (
      .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
      .sck_s(sck_s), .ss_n_s(ss_n_s), .mosi_s(mosi_s),
      .tx_data(tx_data), .tx_wr(tx_wr), .miso(miso),
      .word_start(word_start), .word_done(word_done), .word_data(word_data),
      .busy(busy), .tx_loaded(tx_loaded));

   spi_rx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(word_done), .din(word_data),
      .pop(rx_rd), .dout(rx_data), .full(fifo_full), .empty(fifo_empty));

   assign rx_not_empty = ~fifo_empty;
   assign mode         = hreq_mode_e'(hreq_mode);
   assign rx_cond      = ~busy & ~fifo_full;
   assign tx_cond      = tx_loaded;

   always_comb begin
      unique case (mode)
         HREQ_RX:   hreq = rx_cond;
         HREQ_TX:   hreq = tx_cond;
         HREQ_BOTH: hreq = rx_cond & tx_cond;
         default:   hreq = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rx_overrun <= 1'b0;
      else if (word_done && fifo_full)  rx_overrun <= 1'b1;
      else if (rx_rd)                   rx_overrun <= 1'b0;
   end

   // R1
   hreq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hreq_mode == 2'b00) |-> !hreq);

   // R5
   hreq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_start && hreq_mode == $past(hreq_mode)) |=> !hreq || (hreq_mode != $past(hreq_mode)) || !busy);

   // R9
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && fifo_full) |=> rx_overrun);

   // R8
   not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> rx_not_empty);
endmodule

// File: tb/tb_spi_hreq_slave.sv
module tb_spi_hreq_slave;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, cpol, cpha, tx_wr, rx_rd, sck, ss_n, mosi;
   logic [1:0] hreq_mode;
   logic [7:0] tx_data, rx_data;
   logic       miso, hreq, rx_not_empty, rx_overrun;
   logic       hreq_mid;
   logic [7:0] got;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   spi_hreq_slave dut (
      .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .hreq_mode(hreq_mode),
      .tx_data(tx_data), .tx_wr(tx_wr), .rx_data(rx_data), .rx_rd(rx_rd),
      .rx_not_empty(rx_not_empty), .rx_overrun(rx_overrun),
      .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .hreq(hreq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_tx(input logic [7:0] d);
      tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0; tick(3);
   endtask

   task automatic pop();
      rx_rd = 1'b1; tick(1); rx_rd = 1'b0; tick(1);
   endtask

   task automatic set_mode(input logic p, input logic h);
      cpol = p; cpha = h; sck = p; tick(6);
   endtask

   task automatic xfer(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
      mi = '0; ss_n = 1'b0; tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         if (!cpha) begin
            mosi = mo[7-i]; tick(HALF);
            mi[7-i] = miso; sck = ~cpol;
            if (i == 0) begin tick(5); hreq_mid = hreq; tick(HALF-5); end
            else tick(HALF);
            sck = cpol;
         end else begin
            sck = ~cpol; mosi = mo[7-i];
            if (i == 0) begin tick(5); hreq_mid = hreq; tick(HALF-5); end
            else tick(HALF);
            mi[7-i] = miso; sck = cpol; tick(HALF);
         end
      end
      tick(HALF); ss_n = 1'b1; tick(HALF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; hreq_mode = 2'b00;
      tx_data = '0; tx_wr = 1'b0; rx_rd = 1'b0; sck = 1'b0; ss_n = 1'b1; mosi = 1'b0;
      hreq_mid = 1'b0;
      tick(4); rst_n = 1'b1; tick(4);

      check("R8 reset not_empty", rx_not_empty, 0);
      check("R9 reset overrun", rx_overrun, 0);
      check("R1 off after reset", hreq, 0);
      hreq_mode = 2'b01; tick(1);
      check("R2 idle with space", hreq, 1);

      // R10 sweep over all four SPI modes, R3/R5 host request in transmit mode
      hreq_mode = 2'b10;
      for (int m = 0; m < 4; m++) begin
         set_mode(m[1], m[0]);
         for (int k = 0; k < 6; k++) begin
            logic [7:0] t, o;
            t = 8'((k * 73 + m * 29 + 5) ^ (k << 5));
            o = 8'((k * 151 + m * 11 + 3) ^ 8'hA5);
            write_tx(t);
            check("R3 loaded", hreq, 1);
            xfer(o, 8, got);
            check("R5 dropped at first edge", hreq_mid, 0);
            check("R3 no reload", hreq, 0);
            check("R10 miso word", got, t);
            check("R8 not_empty", rx_not_empty, 1);
            check("R10 mosi word", rx_data, o);
            pop();
            check("R8 empty after read", rx_not_empty, 0);
         end
      end

      // R6 stale transmit word
      set_mode(1'b0, 1'b0);
      write_tx(8'h3C);
      xfer(8'h11, 8, got);
      check("R6 first send", got, 8'h3C);
      xfer(8'h22, 8, got);
      check("R6 resend", got, 8'h3C);
      check("R3 still not loaded", hreq, 0);
      pop(); pop();

      // R7 abort mid-word
      set_mode(1'b1, 1'b1);
      xfer(8'hFF, 4, got);
      check("R7 partial dropped", rx_not_empty, 0);
      write_tx(8'h00);
      xfer(8'h96, 8, got);
      check("R7 next word intact", rx_data, 8'h96);
      pop();

      // R9 / R11 / R2 overrun and order
      hreq_mode = 2'b01; tick(1);
      check("R2 space available", hreq, 1);
      xfer(8'hA1, 8, got);
      xfer(8'hB2, 8, got);
      check("R2 full", hreq, 0);
      check("R9 no overrun yet", rx_overrun, 0);
      xfer(8'hC3, 8, got);
      check("R9 overrun set", rx_overrun, 1);
      check("R11 oldest first", rx_data, 8'hA1);
      pop();
      check("R9 cleared by read", rx_overrun, 0);
      check("R11 second word", rx_data, 8'hB2);
      pop();
      check("R11 drained", rx_not_empty, 0);

      // R4 combined mode
      hreq_mode = 2'b11;
      write_tx(8'h55);
      check("R4 both true", hreq, 1);
      xfer(8'h01, 8, got);
      check("R4 tx not reloaded", hreq, 0);
      write_tx(8'h66);
      xfer(8'h02, 8, got);
      write_tx(8'h77);
      check("R4 queue full", hreq, 0);
      hreq_mode = 2'b10; tick(1);
      check("R3 loaded while full", hreq, 1);
      hreq_mode = 2'b00; tick(1);
      check("R1 off with conditions true", hreq, 0);
      hreq_mode = 2'b11; tick(1);
      pop();
      check("R4 space again", hreq, 1);
      pop();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule